// File: doc/BRIEF.md
# PHY Management Serial Master

This block lets software reach the registers of an external Ethernet PHY over the two-wire management interface (a clock line MDC and a bidirectional data line MDIO). Software writes a single 32-bit command word. The word carries the PHY address, the register address, a read/write flag and, for writes, 16 bits of data. The block then produces one clause-22 management frame on the wires. MDC is divided down from the system clock. MDIO changes only after MDC falls and is sampled when MDC rises.

The same word, read back, gives the status. A busy flag is high for as long as the frame is on the wires, and commands written during that time are dropped. After a read, a read-valid flag is set and the 16 bits returned by the PHY replace the low half of the word. Each completed frame also sets a completion bit in a separate cause register, which software clears with a strobe.

Top module: `phy_mgmt_master`

## Requirements
- R1: After reset the command/status word reads zero, the cause word reads zero, MDC is low and MDIO is not driven (`mdio_oe` low).
- R2: A command write while idle is accepted on that clock edge. From the next cycle the status word shows busy (bit 28) and echoes the command fields: read flag at bit 26, register address at 25:21, PHY address at 20:16, data at 15:0.
- R3: A command write that arrives while busy is ignored. The frame on the wires and the echoed fields are unaffected.
- R4: The frame is 64 bits, sent MSB first. It consists of 32 ones, start bits 0 then 1, opcode 1,0 for a read or 0,1 for a write, the 5-bit PHY address, the 5-bit register address, two turnaround bits and 16 data bits.
- R5: MDC is low while idle. While busy, MDC has a period of 2×HALF_DIV system clocks. MDIO output and enable change only on the cycle in which MDC falls (or when a frame starts).
- R6: On a write, MDIO is driven for all 64 bits, with turnaround 1,0 followed by the 16 write-data bits.
- R7: On a read, MDIO is driven for bits 0 to 45 and released for the two turnaround bits and the 16 data bits. The data bits are sampled on MDC rising edges, MSB first, and written to bits 15:0 of the status word.
- R8: Read-valid (bit 27) is set when a read frame completes. It is cleared by the next accepted command, and it is never set by a write frame.
- R9: Busy stays high for exactly 128×HALF_DIV system clocks per frame.
- R10: Completion of any frame sets bit 29 of the cause word. A `cause_clr` strobe clears it, and a completion in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Command word write strobe |
| reg_wdata | input | 32 | Command word write data |
| cmd_rdata | output | 32 | Command/status word read value |
| cause_clr | input | 1 | Clears the completion cause bit |
| cause_rdata | output | 32 | Cause word, completion at bit 29 |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
The bench builds the block with HALF_DIV set to 2. At that setting a frame lasts 256 cycles, so a sweep over all 32 PHY addresses fits easily in the cycle budget. Each address uses a different register address and alternates reads with writes, and every bit is checked against a frame computed in the bench. The alternation puts a write straight after each read, which exercises the clearing of read-valid. A write injected in the middle of some frames exercises the busy lockout.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_POS     = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int DATA_POS   = TA_POS + 2;

    // status word bit positions that software decodes
    localparam int POS_RD     = 26;
    localparam int POS_RVALID = 27;
    localparam int POS_BUSY   = 28;
    localparam int POS_DONE   = 29;

    // packed so that it maps directly onto bits 26:0 of the command word
    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] reg_a;
        logic [ADDR_W-1:0] phy_a;
        logic [DATA_W-1:0] data;
    } mgmt_cmd_t;

    localparam int CMD_W = $bits(mgmt_cmd_t);

    function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_cmd_t c);
        logic [1:0] op;
        logic [1:0] ta;
        op = c.rd ? 2'b10 : 2'b01;
        ta = c.rd ? 2'b11 : 2'b10;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy_a, c.reg_a, ta,
                (c.rd ? {DATA_W{1'b1}} : c.data)};
    endfunction

endpackage

// File: rtl/mdc_tick_gen.sv
module mdc_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LIM = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LIM);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
    import phy_mgmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  rd_in,
    input  logic                  tick,
    input  logic                  mdio_in,
    output logic                  mdc,
    output logic                  mdio_out,
    output logic                  mdio_oe,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST  = IW'(FRAME_BITS - 1);
    localparam logic [IW-1:0] TA_I  = IW'(TA_POS);
    localparam logic [IW-1:0] DAT_I = IW'(DATA_POS);

    logic                  busy_q, mdc_q, rd_q, oe_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [IW-1:0]         idx_q;
    logic [DATA_W-1:0]     cap_q;
    logic [IW-1:0]         idx_nx;

    assign idx_nx   = idx_q + IW'(1);
    assign done     = busy_q && tick && mdc_q && (idx_q == LAST);
    assign busy     = busy_q;
    assign mdc      = mdc_q;
    assign mdio_out = sh_q[FRAME_BITS-1];
    assign mdio_oe  = oe_q;
    assign rd_data  = cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            mdc_q  <= 1'b0;
            rd_q   <= 1'b0;
            oe_q   <= 1'b0;
            sh_q   <= '0;
            idx_q  <= '0;
            cap_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            mdc_q  <= 1'b0;
            sh_q   <= frame_in;
            idx_q  <= '0;
            rd_q   <= rd_in;
            oe_q   <= 1'b1;
        end else if (busy_q && tick) begin
            if (!mdc_q) begin
                mdc_q <= 1'b1;
                if (rd_q && idx_q >= DAT_I) cap_q <= {cap_q[DATA_W-2:0], mdio_in};
            end else begin
                mdc_q <= 1'b0;
                if (idx_q == LAST) begin
                    busy_q <= 1'b0;
                    oe_q   <= 1'b0;
                end else begin
                    idx_q <= idx_nx;
                    sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                    oe_q  <= !(rd_q && idx_nx >= TA_I);
                end
            end
        end
    end
endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
    import phy_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] cmd_rdata,
    input  logic        cause_clr,
    output logic [31:0] cause_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    mgmt_cmd_t         cmd_q, cmd_new;
    logic              rvalid_q, cause_q;
    logic              tick, busy, done, accept;
    logic [DATA_W-1:0] rd_data;

    assign cmd_new = mgmt_cmd_t'(reg_wdata[CMD_W-1:0]);
    assign accept  = reg_wr && !busy;

    mdc_tick_gen #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .tick(tick)
    );

    mgmt_frame_engine i_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .frame_in(build_frame(cmd_new)),
        .rd_in   (cmd_new.rd),
        .tick    (tick),
        .mdio_in (mdio_in),
        .mdc     (mdc),
        .mdio_out(mdio_out),
        .mdio_oe (mdio_oe),
        .busy    (busy),
        .done    (done),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            rvalid_q <= 1'b0;
            cause_q  <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q    <= cmd_new;
                rvalid_q <= 1'b0;
            end else if (done && cmd_q.rd) begin
                cmd_q.data <= rd_data;
                rvalid_q   <= 1'b1;
            end
            if (done)           cause_q <= 1'b1;
            else if (cause_clr) cause_q <= 1'b0;
        end
    end

    always_comb begin
        cmd_rdata                  = '0;
        cmd_rdata[CMD_W-1:0]       = cmd_q;
        cmd_rdata[POS_RVALID]      = rvalid_q;
        cmd_rdata[POS_BUSY]        = busy;
        cause_rdata                = '0;
        cause_rdata[POS_DONE]      = cause_q;
    end
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [31:0] cmd_rdata,
    input logic [31:0] cause_rdata,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe
);
    logic busy, rvalid, rd;
    assign busy   = cmd_rdata[28];
    assign rvalid = cmd_rdata[27];
    assign rd     = cmd_rdata[26];

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy && reg_wr |=> $stable(cmd_rdata[26:16])); // R3

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc && !mdio_oe); // R5

    AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !$fell(mdc) |-> $stable(mdio_out) && $stable(mdio_oe)); // R5

    AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> !busy); // R8

    AST_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && !rd |-> !rvalid); // R8

    AST_READ_RVALID: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && rd |-> rvalid); // R7

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> cause_rdata[29]); // R10
endmodule

bind phy_mgmt_master phy_mgmt_checker i_checker (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .cmd_rdata  (cmd_rdata),
    .cause_rdata(cause_rdata),
    .mdc        (mdc),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe)
);

// File: tb/test_phy_mgmt_master.sv
`timescale 1ns/1ps
module test_phy_mgmt_master;
    localparam int HD = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        cause_clr = 1'b0;
    logic [31:0] cmd_rdata, cause_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int n_checks = 0;
    int n_errs   = 0;
    int txn_id   = 0;
    int seen_id  = 0;
    int cap_n    = 0;
    int cyc      = 0;
    int rise_t0  = 0;
    int rise_t1  = 0;
    logic [63:0] cap_out, cap_oe;
    logic [15:0] rd_pat = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phy_mgmt_master #(.HALF_DIV(HD)) i_phy_mgmt_master (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .cmd_rdata(cmd_rdata), .cause_clr(cause_clr), .cause_rdata(cause_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // PHY-side model: records bits on MDC rise, drives read data after MDC falls
    always @(posedge mdc or negedge mdc) begin
        if (txn_id != seen_id) begin
            seen_id = txn_id;
            cap_n   = 0;
        end
        if (mdc) begin
            if (cap_n == 0) rise_t0 = cyc;
            if (cap_n == 1) rise_t1 = cyc;
            if (cap_n < 64) begin
                cap_out[63-cap_n] = mdio_out;
                cap_oe[63-cap_n]  = mdio_oe;
            end
            cap_n = cap_n + 1;
        end else begin
            if (cap_n >= 48 && cap_n <= 63) mdio_in = rd_pat[63-cap_n];
            else                            mdio_in = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] data, input logic [15:0] rpat,
                           input bit inject);
        logic [63:0] exp_f, exp_oe;
        logic [31:0] word;
        int n;
        txn_id++;
        rd_pat = rpat;
        word = {5'b0, rd, ra, phy, data};
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = word;
        @(negedge clk);
        reg_wr = 1'b0;
        chk(cmd_rdata[28] == 1'b1, "R2", "busy after accept", 64'(cmd_rdata[28]), 64'd1);
        chk(cmd_rdata[26:0] == word[26:0], "R2", "echoed fields",
            64'(cmd_rdata[26:0]), 64'(word[26:0]));
        chk(cmd_rdata[27] == 1'b0, "R8", "rvalid cleared by command",
            64'(cmd_rdata[27]), 64'd0);
        n = 0;
        while (cmd_rdata[28] && n < 5000) begin
            if (inject && n == 40) begin
                reg_wr = 1'b1; reg_wdata = ~word;
            end else reg_wr = 1'b0;
            n++;
            @(negedge clk);
        end
        reg_wr = 1'b0;
        chk(n == 128 * HD, "R9", "busy length", 64'(n), 64'(128 * HD));
        chk(rise_t1 - rise_t0 == 2 * HD, "R5", "MDC period",
            64'(rise_t1 - rise_t0), 64'(2 * HD));
        exp_f  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, data};
        exp_oe = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        chk(cap_n == 64, "R4", "bit count", 64'(cap_n), 64'd64);
        chk(cap_oe == exp_oe, rd ? "R7" : "R6", "drive enable pattern", cap_oe, exp_oe);
        chk((cap_out & exp_oe) == (exp_f & exp_oe), "R4", "frame bits",
            cap_out & exp_oe, exp_f & exp_oe);
        if (inject)
            chk(cmd_rdata[26:16] == word[26:16], "R3", "fields after ignored write",
                64'(cmd_rdata[26:16]), 64'(word[26:16]));
        if (rd) begin
            chk(cmd_rdata[15:0] == rpat, "R7", "read data", 64'(cmd_rdata[15:0]), 64'(rpat));
            chk(cmd_rdata[27] == 1'b1, "R7", "rvalid after read", 64'(cmd_rdata[27]), 64'd1);
        end else begin
            chk(cmd_rdata[27] == 1'b0, "R8", "no rvalid on write", 64'(cmd_rdata[27]), 64'd0);
            chk(cmd_rdata[15:0] == data, "R6", "write data kept", 64'(cmd_rdata[15:0]), 64'(data));
        end
        chk(cause_rdata[29] == 1'b1, "R10", "done cause set", 64'(cause_rdata), 64'h2000_0000);
        cause_clr = 1'b1;
        @(negedge clk);
        cause_clr = 1'b0;
        chk(cause_rdata == 32'h0, "R10", "done cause cleared", 64'(cause_rdata), 64'd0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_rdata == 32'h0, "R1", "status after reset", 64'(cmd_rdata), 64'd0);
        chk(cause_rdata == 32'h0, "R1", "cause after reset", 64'(cause_rdata), 64'd0);
        chk(!mdc && !mdio_oe, "R1", "lines after reset", 64'({mdc, mdio_oe}), 64'd0);
        for (int p = 0; p < 32; p++) begin
            run_txn(p[0], 5'(p), 5'(31 - p), 16'(p * 16'h0811) ^ 16'hA5C3,
                    16'(16'h1357 * (p + 1)), (p % 5) == 2);
        end
        chk(!mdc && !mdio_oe, "R5", "lines idle at end", 64'({mdc, mdio_oe}), 64'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule